// File: doc/BRIEF.md
# Dual-Channel Programmable Pulse Generator

The block produces two continuous rectangular waves. Each channel holds a low-time and a high-time reload byte. A down counter takes these values in turn. Each time the counter passes zero, it takes the other value and the pin level flips. A low phase therefore lasts T×(L+1) and a high phase lasts T×(H+1), where T is the period of the channel's selected count tick.

A mode field sets how the two channels work together. They can run as two independent 8-bit generators. They can also form one 16-bit generator, where channel B's bytes are the upper halves. In the cascade mode, channel B counts the zero crossings of channel A rather than prescaler ticks.

Software writes all settings through a simple byte write port. The prescaler supplies a vector of divided tick strobes, and each channel's 3-bit select picks one of them.

Top module: `ppg_dual`

## Requirements
- R1: After reset, both pins are low and every setting reads as zero. These zero settings are reload 0, enable 0, select 0 and split mode. Enabling channel A with no other write therefore gives one-cycle low and one-cycle high phases at divide-by-1.
- R2: The write port maps its addresses as follows.
  - Address 0 is the A low byte and address 1 is the A high byte.
  - Address 2 is the B low byte and address 3 is the B high byte.
  - Address 4 is the A control and address 5 is the B control. In a control byte, bit 0 is the enable and bits 3:1 are the tick select.
  - Address 6 is the mode, in bits 1:0. The mode value 0 is split, 1 is wide, 2 is cascade, and 3 behaves as split.
- R3: When the enable goes from 0 to 1, the pin starts low and the counter loads the low byte. Counting begins at the next selected tick. At divide-by-1, the pin first rises L+2 clock cycles after the enabling write edge.
- R4: In steady state the low phase lasts T×(L+1) cycles and the high phase lasts T×(H+1) cycles.
- R5: Tick select value s takes the prescaler strobe of divide-by-2^s, so T = 2^s.
- R6: Clearing the enable halts the counter, and the pin is low from the second cycle after the write. The pin stays low until the channel is enabled again.
- R7: A reload byte written while a phase runs does not change that phase. The new byte is used at the next reload of that byte. A write that lands on the same edge as the reload is used at the reload after that one.
- R8: In wide mode, the low value is {B low, A low} and the high value is {B high, A high}. The 16-bit counter runs under A's enable and select, the wave appears on pin B, and pin A stays low.
- R9: In cascade mode, channel B takes one count step per zero crossing of channel A. Channel A itself runs unchanged on pin A.
- R10: In split mode, the two channels run at the same time with their own reload bytes and selects, and neither disturbs the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the setting registers |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| div_ticks | input | 8 | Prescaler strobes; bit k pulses once every 2^k cycles |
| pwm_a | output | 1 | Channel A pin |
| pwm_b | output | 1 | Channel B pin, or the wide-mode output |

## Verification
A reload byte can be written on the same edge where the counter takes that byte at a zero crossing. This is the case where two of the block's functions fall in one cycle. The bench provokes it by counting clock cycles from an observed rising edge, so that a new low byte lands exactly on the edge that ends the high phase. The coming low phase must still have the old width, and only the low phase after it may show the new width. A second alignment writes a new high byte in the middle of a high phase. That phase must keep its full length, and the following high phase must change.

// File: rtl/ppg_pkg.sv
package ppg_pkg;
  localparam int RW   = 8;
  localparam int SELW = 3;
  localparam int AW   = 3;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'd0,
    MODE_WIDE  = 2'd1,
    MODE_CASC  = 2'd2,
    MODE_ALT   = 2'd3
  } mode_e;

  typedef struct packed {
    logic [SELW-1:0] sel;
    logic            en;
  } ctl_t;

  localparam logic [AW-1:0] ADR_LO_A  = 3'd0;
  localparam logic [AW-1:0] ADR_HI_A  = 3'd1;
  localparam logic [AW-1:0] ADR_LO_B  = 3'd2;
  localparam logic [AW-1:0] ADR_HI_B  = 3'd3;
  localparam logic [AW-1:0] ADR_CTL_A = 3'd4;
  localparam logic [AW-1:0] ADR_CTL_B = 3'd5;
  localparam logic [AW-1:0] ADR_MODE  = 3'd6;

  // cycles spent in one phase for reload value val at tick select sel
  function automatic int unsigned phase_len(input int unsigned val, input int unsigned sel);
    return (val + 1) << sel;
  endfunction
endpackage

// File: rtl/ppg_regs.sv
module ppg_regs
  import ppg_pkg::*;
#(
  parameter int DW = RW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic [1:0][DW-1:0]   lo_val,
  output logic [1:0][DW-1:0]   hi_val,
  output ctl_t [1:0]           ctl,
  output mode_e                mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_val <= '0;
      hi_val <= '0;
      ctl    <= '0;
      mode   <= MODE_SPLIT;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADR_LO_A:  lo_val[0] <= wr_data;
        ADR_HI_A:  hi_val[0] <= wr_data;
        ADR_LO_B:  lo_val[1] <= wr_data;
        ADR_HI_B:  hi_val[1] <= wr_data;
        ADR_CTL_A: ctl[0]    <= ctl_t'(wr_data[SELW:0]);
        ADR_CTL_B: ctl[1]    <= ctl_t'(wr_data[SELW:0]);
        ADR_MODE:  mode      <= mode_e'(wr_data[1:0]);
        default: ;
      endcase
    end
  end

  a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_MODE) |=> (mode == $past(wr_data[1:0])));
  a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADR_CTL_A) |=> (ctl[0].en == $past(wr_data[0])));
endmodule

// File: rtl/ppg_tick_sel.sv
module ppg_tick_sel
  import ppg_pkg::*;
#(
  parameter int SW   = SELW,
  localparam int ND  = 1 << SW
) (
  input  logic [ND-1:0] div_ticks,
  input  logic [SW-1:0] sel,
  output logic          tick
);
  assign tick = div_ticks[sel];
endmodule

// File: rtl/ppg_core.sv
module ppg_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] lo_val,
  input  logic [W-1:0] hi_val,
  output logic         level,
  output logic         uf
);
  logic [W-1:0] cnt;
  logic         en_d;
  logic         start;
  logic         run;

  assign start = en & ~en_d;
  assign run   = en & en_d;
  assign uf    = run & tick & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      en_d  <= 1'b0;
      level <= 1'b0;
    end else begin
      en_d <= en;
      if (!en) begin
        level <= 1'b0;
      end else if (start) begin
        cnt   <= lo_val;
        level <= 1'b0;
      end else if (uf) begin
        level <= ~level;
        cnt   <= level ? lo_val : hi_val;
      end else if (run && tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!level && cnt == $past(lo_val)));
  a_r4_flip_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
    uf |=> (level != $past(level)));
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
  a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));
  a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!level && $stable(cnt)));
endmodule

// File: rtl/ppg_dual.sv
module ppg_dual
  import ppg_pkg::*;
#(
  parameter int DW   = RW,
  parameter int SW   = SELW,
  localparam int ND  = 1 << SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [ND-1:0] div_ticks,
  output logic          pwm_a,
  output logic          pwm_b
);
  logic [1:0][DW-1:0] lo_val, hi_val;
  ctl_t [1:0]         ctl;
  mode_e              mode;
  logic               wide, casc;
  logic [1:0]         tick_sel, core_tick, core_en, level, uf;
  logic               level_w, uf_w;

  ppg_regs #(.DW(DW)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .lo_val, .hi_val, .ctl, .mode
  );

  assign wide = (mode == MODE_WIDE);
  assign casc = (mode == MODE_CASC);

  for (genvar i = 0; i < 2; i++) begin : g_ch
    ppg_tick_sel #(.SW(SW)) u_sel (
      .div_ticks, .sel(ctl[i].sel[SW-1:0]), .tick(tick_sel[i])
    );
    if (i == 0) begin : g_lead
      assign core_tick[i] = tick_sel[i];
    end else begin : g_follow
      assign core_tick[i] = casc ? uf[0] : tick_sel[i];
    end
    assign core_en[i] = ctl[i].en & ~wide;
    ppg_core #(.W(DW)) u_core (
      .clk, .rst_n, .en(core_en[i]), .tick(core_tick[i]),
      .lo_val(lo_val[i]), .hi_val(hi_val[i]),
      .level(level[i]), .uf(uf[i])
    );
  end

  ppg_core #(.W(2*DW)) u_wide (
    .clk, .rst_n, .en(ctl[0].en & wide), .tick(tick_sel[0]),
    .lo_val({lo_val[1], lo_val[0]}), .hi_val({hi_val[1], hi_val[0]}),
    .level(level_w), .uf(uf_w)
  );

  assign pwm_a = level[0];
  assign pwm_b = wide ? level_w : level[1];

  a_r8_wide_quiet_a: assert property (@(posedge clk) disable iff (!rst_n)
    wide |=> !pwm_a);
  a_r8_wide_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (wide && uf_w) |=> (!wide || pwm_b != $past(pwm_b)));
  a_r9_casc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (casc && uf[1]) |-> uf[0]);
endmodule

// File: tb/tb_ppg_dual.sv
`timescale 1ns/1ps
module tb_ppg_dual;
  import ppg_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] div_ticks;
  logic       pwm_a, pwm_b;
  logic [7:0] fc;
  int         checks = 0;
  int         errors = 0;

  always #5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) fc <= '0;
    else        fc <= fc + 1'b1;
  end
  always_comb begin
    for (int k = 0; k < 8; k++) div_ticks[k] = ((fc & ((8'd1 << k) - 8'd1)) == 8'd0);
  end

  ppg_dual dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .div_ticks, .pwm_a, .pwm_b);

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  lo_a, hi_a, lo_b, hi_b;
    logic [2:0]  sel_a, sel_b;
    logic [15:0] ea_lo, ea_hi, eb_lo, eb_hi;
  } vec_t;

  // expected widths in clock cycles; 0 on channel A means the pin must stay low
  localparam vec_t VECS [9] = '{
    '{2'd0, 8'd3,   8'd5,   8'd7,  8'd2,   3'd0, 3'd1, 16'd4,   16'd6,   16'd16,  16'd6},
    '{2'd0, 8'd0,   8'd0,   8'd10, 8'd0,   3'd0, 3'd2, 16'd1,   16'd1,   16'd44,  16'd4},
    '{2'd0, 8'd255, 8'd1,   8'd1,  8'd254, 3'd0, 3'd0, 16'd256, 16'd2,   16'd2,   16'd255},
    '{2'd0, 8'd0,   8'd1,   8'd2,  8'd2,   3'd7, 3'd3, 16'd128, 16'd256, 16'd24,  16'd24},
    '{2'd1, 8'd4,   8'd9,   8'd1,  8'd0,   3'd0, 3'd5, 16'd0,   16'd0,   16'd261, 16'd10},
    '{2'd1, 8'd0,   8'd255, 8'd0,  8'd0,   3'd1, 3'd0, 16'd0,   16'd0,   16'd2,   16'd512},
    '{2'd2, 8'd2,   8'd2,   8'd1,  8'd3,   3'd0, 3'd4, 16'd3,   16'd3,   16'd6,   16'd12},
    '{2'd2, 8'd0,   8'd0,   8'd4,  8'd0,   3'd1, 3'd0, 16'd2,   16'd2,   16'd10,  16'd2},
    '{2'd3, 8'd1,   8'd1,   8'd0,  8'd2,   3'd0, 3'd0, 16'd2,   16'd2,   16'd1,   16'd3}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic pin(input int which);
    return (which != 0) ? pwm_b : pwm_a;
  endfunction

  task automatic measure(input int which, output int hi_w, output int lo_w);
    int guard = 0;
    hi_w = -1; lo_w = -1;
    while (pin(which) != 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    while (pin(which) != 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    if (guard >= 4000) return;
    hi_w = 0;
    while (pin(which) == 1'b1 && hi_w < 4000) begin hi_w++; @(negedge clk); end
    lo_w = 0;
    while (pin(which) == 1'b0 && lo_w < 4000) begin lo_w++; @(negedge clk); end
  endtask

  task automatic count_high(input int which, input int n, output int seen);
    seen = 0;
    for (int k = 0; k < n; k++) begin
      if (pin(which)) seen++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(10ns * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hw, lw, seen;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    count_high(0, 5, seen); check("R1 pin A low after reset", seen, 0);
    count_high(1, 5, seen); check("R1 pin B low after reset", seen, 0);
    wr(ADR_CTL_A, 8'h01);
    measure(0, hw, lw);
    check("R1 zero reload high", hw, 1);
    check("R1 zero reload low", lw, 1);

    // table walk: R2 R4 R5 R8 R9 R10
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      wr(ADR_CTL_A, 8'h00);
      wr(ADR_CTL_B, 8'h00);
      wr(ADR_MODE, {6'd0, v.mode});
      wr(ADR_LO_A, v.lo_a); wr(ADR_HI_A, v.hi_a);
      wr(ADR_LO_B, v.lo_b); wr(ADR_HI_B, v.hi_b);
      wr(ADR_CTL_A, {4'd0, v.sel_a, 1'b1});
      wr(ADR_CTL_B, {4'd0, v.sel_b, 1'b1});
      if (v.ea_hi == 0) begin
        count_high(0, 300, seen);
        check($sformatf("R8 vec%0d pin A quiet", i), seen, 0);
      end else begin
        measure(0, hw, lw);
        check($sformatf("R4 R5 R9 R10 vec%0d A high", i), hw, int'(v.ea_hi));
        check($sformatf("R4 R5 R9 R10 vec%0d A low", i), lw, int'(v.ea_lo));
      end
      measure(1, hw, lw);
      check($sformatf("R4 R5 R8 R9 R10 vec%0d B high", i), hw, int'(v.eb_hi));
      check($sformatf("R4 R5 R8 R9 R10 vec%0d B low", i), lw, int'(v.eb_lo));
    end

    // R6 disable, then R3 restart timing
    wr(ADR_CTL_A, 8'h00); wr(ADR_CTL_B, 8'h00); wr(ADR_MODE, 8'h00);
    wr(ADR_LO_A, 8'd5); wr(ADR_HI_A, 8'd5);
    wr(ADR_CTL_A, 8'h01);
    while (!pwm_a) @(negedge clk);
    wr(ADR_CTL_A, 8'h00);
    @(negedge clk);
    count_high(0, 40, seen);
    check("R6 pin A low after disable", seen, 0);
    wr(ADR_CTL_A, 8'h01);
    seen = 0;
    while (!pwm_a && seen < 100) begin seen++; @(negedge clk); end
    check("R3 first rise after enable", seen, 7);

    // R7 high byte written inside a running high phase
    wr(ADR_CTL_A, 8'h00);
    wr(ADR_LO_A, 8'd6); wr(ADR_HI_A, 8'd6);
    wr(ADR_CTL_A, 8'h01);
    while (!pwm_a) @(negedge clk);
    while (pwm_a) @(negedge clk);
    while (!pwm_a) @(negedge clk);
    hw = 1;
    wr_en = 1'b1; wr_addr = ADR_HI_A; wr_data = 8'd2;
    @(negedge clk);
    wr_en = 1'b0;
    while (pwm_a) begin hw++; @(negedge clk); end
    check("R7 running high phase kept", hw, 7);
    lw = 0;
    while (!pwm_a) begin lw++; @(negedge clk); end
    check("R7 low phase unchanged", lw, 7);
    hw = 0;
    while (pwm_a) begin hw++; @(negedge clk); end
    check("R7 next high uses new byte", hw, 3);

    // R7 low byte written on the very edge of the reload into the low phase
    wr(ADR_CTL_A, 8'h00);
    wr(ADR_LO_A, 8'd4); wr(ADR_HI_A, 8'd3);
    wr(ADR_CTL_A, 8'h01);
    while (!pwm_a) @(negedge clk);
    while (pwm_a) @(negedge clk);
    while (!pwm_a) @(negedge clk);
    repeat (3) @(negedge clk);
    wr_en = 1'b1; wr_addr = ADR_LO_A; wr_data = 8'd1;
    @(negedge clk);
    wr_en = 1'b0;
    lw = 0;
    while (!pwm_a) begin lw++; @(negedge clk); end
    check("R7 coincident write keeps old low", lw, 5);
    hw = 0;
    while (pwm_a) begin hw++; @(negedge clk); end
    check("R7 high after coincident write", hw, 4);
    lw = 0;
    while (!pwm_a) begin lw++; @(negedge clk); end
    check("R7 following low uses new byte", lw, 2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule